// File: doc/BRIEF.md
# Refresh Scheduler with Delay-Line Tracking Window

This block decides when a DDR or DDR2 SDRAM controller sends an auto-refresh and when the delay-locked loop that positions the read strobe may retune. A down-counter is loaded with a configured interval. Each time it runs out it reloads at once and raises a refresh request. The request waits until the command sequencer is idle. The sequencer counts as busy while it reports a transaction, and also for a fixed number of cycles after it signals the start of a burst. The refresh strobe therefore comes out in the first idle cycle. While a request waits with the sequencer idle, the block tells the sequencer not to begin new work.

The delay-line update enable opens for the refresh strobe cycle and for a fixed number of cycles after it. It is forced low in every cycle in which a read is active. While the enable is low, the loop keeps its selected delay frozen. Because a refresh can be pushed back by in-flight work, the configured interval should be set a few cycles short of the target spacing. Up to eight cycles short covers the worst case. A second expiry that arrives while a request is still waiting sets a sticky overflow flag.

Top module: `rfs_dll_sched`

## Requirements
- R1: During and right after synchronous active-low reset, `refresh_o`, `dll_update_o`, `overflow_o` and `start_hold_o` are 0, and the counter holds the value of `interval_i`. With interval I and no other activity, the first expiry happens I-1 cycles after the first cycle out of reset.
- R2: The counter expires once every `interval_i` cycles. At each expiry it reloads from the value `interval_i` has in that cycle. With an interval of 1, the counter expires in every cycle.
- R3: With the sequencer idle (`txn_busy_i` = 0 and no burst in progress), `refresh_o` is 1 for exactly one cycle. That cycle is the one right after the expiry.
- R4: While `txn_busy_i` = 1, `refresh_o` stays 0. A waiting request is issued in the first cycle with `txn_busy_i` = 0.
- R5: A pulse on `burst_start_i` makes the sequencer count as busy for BURST_CYCLES cycles, starting with the pulse cycle (default 3). If the burst starts in the expiry cycle, the refresh is issued BURST_CYCLES cycles after the expiry.
- R6: A deferred refresh does not move later expiries. They stay on the grid of multiples of the interval, counted from reset.
- R7: If an expiry happens while a request is waiting and no refresh is issued in that cycle, `overflow_o` becomes 1 in the next cycle. It stays 1 until reset.
- R8: `start_hold_o` is 1 in the expiry cycle and in every cycle in which a request is waiting. It is 0 otherwise.
- R9: `dll_update_o` is 1 in the refresh strobe cycle and in the DLL_TAIL cycles after it (default 4). It is 0 in all other cycles.
- R10: `dll_update_o` is 0 in every cycle in which `read_active_i` = 1, even inside the window of R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| interval_i | input | CNT_W | Refresh interval in cycles; sampled at each reload |
| txn_busy_i | input | 1 | Sequencer reports a transaction in progress |
| burst_start_i | input | 1 | Sequencer starts a burst in this cycle |
| read_active_i | input | 1 | A read capture is in progress |
| refresh_o | output | 1 | One-cycle auto-refresh command strobe |
| dll_update_o | output | 1 | Delay-locked loop may retune in this cycle |
| start_hold_o | output | 1 | Sequencer must not begin a new transaction |
| overflow_o | output | 1 | Sticky: an expiry arrived while a request was still waiting |

## Verification
The hardest case to reach is an expiry that lands while an earlier request is still waiting. That case sets the overflow flag. It also shows whether deferral moves the counter's grid. The bench holds `txn_busy_i` high for longer than a whole interval, so that a second expiry falls inside the busy stretch. It then checks the flag, the late strobe and the next expiry against cycle numbers computed from reset. Two other cases need exact timing: a burst started in the expiry cycle itself, and an interval of 1, where an expiry and an issue fall in the same cycle.

// File: rtl/rfs_pkg.sv
// Package rfs_pkg
// Shared helpers for the refresh scheduler. Assumes nothing beyond the
// standard elaboration-time evaluation of constant functions.
package rfs_pkg;

    // Width needed to hold values 0..n, never less than one bit.
    function automatic int rfs_width(input int n);
        int w;
        w = $clog2(n + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/rfs_interval_timer.sv
// Module rfs_interval_timer
// Down-counter that flags an expiry when it reaches one and reloads from
// interval_i in that same cycle, so expiries keep a fixed grid whatever
// happens downstream. Assumes interval_i >= 1 (0 behaves like 1).
module rfs_interval_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] interval_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;

    // Expiry when the count has reached its last cycle.
    assign expire_o = (cnt_q <= CNT_W'(1));

    // Count down; reload on expiry and on reset.
    always_ff @(posedge clk) begin
        if (!rst_n || expire_o) cnt_q <= interval_i;
        else                    cnt_q <= cnt_q - CNT_W'(1);
    end

    AST_RELOAD_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(expire_o) && $past(rst_n) |-> cnt_q == $past(interval_i)); // R2
endmodule

// File: rtl/rfs_burst_tracker.sv
// Module rfs_burst_tracker
// Counts a burst as occupying BURST_CYCLES cycles, counting from the cycle of
// burst_start_i. Assumes the sequencer pulses burst_start_i once per burst.
module rfs_burst_tracker #(
    parameter int BURST_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic burst_start_i,
    output logic burst_busy_o
);
    import rfs_pkg::*;
    localparam int BW = rfs_width(BURST_CYCLES);

    generate
        if (BURST_CYCLES <= 1) begin : g_single
            // A one-cycle burst is busy only in its start cycle.
            assign burst_busy_o = burst_start_i;
        end else begin : g_multi
            logic [BW-1:0] rem_q;

            // Load the remaining busy cycles on a start, then drain.
            always_ff @(posedge clk) begin
                if (!rst_n)             rem_q <= '0;
                else if (burst_start_i) rem_q <= BW'(BURST_CYCLES - 1);
                else if (rem_q != '0)   rem_q <= rem_q - BW'(1);
            end

            assign burst_busy_o = burst_start_i || (rem_q != '0);

            AST_BURST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                burst_start_i |=> burst_busy_o); // R5
        end
    endgenerate
endmodule

// File: rtl/rfs_dll_window.sv
// Module rfs_dll_window
// Opens the delay-line update enable for the refresh strobe cycle plus
// DLL_TAIL cycles after it, and forces it low while a read is active.
// Assumes refresh_i is a single-cycle strobe.
module rfs_dll_window #(
    parameter int DLL_TAIL = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic refresh_i,
    input  logic read_active_i,
    output logic dll_update_o
);
    import rfs_pkg::*;
    localparam int TW = rfs_width(DLL_TAIL);

    logic tail_active;

    generate
        if (DLL_TAIL == 0) begin : g_no_tail
            assign tail_active = 1'b0;
        end else begin : g_tail
            logic [TW-1:0] tail_q;

            // Restart the tail on each strobe, otherwise count it out.
            always_ff @(posedge clk) begin
                if (!rst_n)            tail_q <= '0;
                else if (refresh_i)    tail_q <= TW'(DLL_TAIL);
                else if (tail_q != '0) tail_q <= tail_q - TW'(1);
            end

            assign tail_active = (tail_q != '0);

            AST_TAIL_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
                tail_active |-> $past(refresh_i) || $past(tail_active)); // R9
        end
    endgenerate

    // Window open and no read capture in progress.
    assign dll_update_o = (refresh_i || tail_active) && !read_active_i;

    AST_DLL_FROZEN_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        read_active_i |-> !dll_update_o); // R10
endmodule

// File: rtl/rfs_dll_sched.sv
// Module rfs_dll_sched
// Top of the refresh scheduler. Latches a request at each timer expiry,
// issues it in the first cycle the sequencer is idle, holds off new work
// while it waits, flags an expiry that meets a waiting request, and opens
// the delay-line update window around each refresh.
// Assumes the sequencer honours start_hold_o.
module rfs_dll_sched #(
    parameter int CNT_W        = 16,
    parameter int BURST_CYCLES = 3,
    parameter int DLL_TAIL     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] interval_i,
    input  logic             txn_busy_i,
    input  logic             burst_start_i,
    input  logic             read_active_i,
    output logic             refresh_o,
    output logic             dll_update_o,
    output logic             start_hold_o,
    output logic             overflow_o
);
    logic expire;
    logic burst_busy;
    logic seq_busy;
    logic pend_q;
    logic ovf_q;

    rfs_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .interval_i (interval_i),
        .expire_o   (expire)
    );

    rfs_burst_tracker #(.BURST_CYCLES(BURST_CYCLES)) u_burst (
        .clk           (clk),
        .rst_n         (rst_n),
        .burst_start_i (burst_start_i),
        .burst_busy_o  (burst_busy)
    );

    assign seq_busy  = txn_busy_i || burst_busy;
    assign refresh_o = pend_q && !seq_busy;

    // Request latch: set on expiry, cleared when the strobe goes out.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend_q <= 1'b0;
        else if (expire)    pend_q <= 1'b1;
        else if (refresh_o) pend_q <= 1'b0;
    end

    // Sticky overflow: an expiry while a request still waits unissued.
    always_ff @(posedge clk) begin
        if (!rst_n)                              ovf_q <= 1'b0;
        else if (expire && pend_q && !refresh_o) ovf_q <= 1'b1;
    end

    assign overflow_o   = ovf_q;
    assign start_hold_o = pend_q || expire;

    rfs_dll_window #(.DLL_TAIL(DLL_TAIL)) u_dll (
        .clk           (clk),
        .rst_n         (rst_n),
        .refresh_i     (refresh_o),
        .read_active_i (read_active_i),
        .dll_update_o  (dll_update_o)
    );

    AST_REQUEST_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> pend_q); // R3
    AST_NO_REFRESH_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        burst_busy |-> !refresh_o); // R5
    AST_NO_REFRESH_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        txn_busy_i |-> !refresh_o); // R4
    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(overflow_o) |-> overflow_o); // R7
    AST_HOLD_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> start_hold_o); // R8
endmodule

// File: tb/rfs_dll_sched_bench.sv
module rfs_dll_sched_bench;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] interval_i = 16'd10;
    logic             txn_busy_i = 1'b0;
    logic             burst_start_i = 1'b0;
    logic             read_active_i = 1'b0;
    logic             refresh_o, dll_update_o, start_hold_o, overflow_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    rfs_dll_sched #(.CNT_W(CNT_W), .BURST_CYCLES(3), .DLL_TAIL(4)) u_rfs_dll_sched (
        .clk           (clk),
        .rst_n         (rst_n),
        .interval_i    (interval_i),
        .txn_busy_i    (txn_busy_i),
        .burst_start_i (burst_start_i),
        .read_active_i (read_active_i),
        .refresh_o     (refresh_o),
        .dll_update_o  (dll_update_o),
        .start_hold_o  (start_hold_o),
        .overflow_o    (overflow_o)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cyc, act, exp);
        end
    endtask

    // Reset with the given interval; cycle 0 is the first cycle out of reset.
    task automatic apply_reset(input int ival);
        rst_n = 1'b0; interval_i = CNT_W'(ival);
        txn_busy_i = 0; burst_start_i = 0; read_active_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; cyc = 0;
        #1;
    endtask

    // Advance to the middle of cycle c (inputs set after the call apply to it).
    task automatic to_cycle(input int c);
        while (cyc < c) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic settle; #1; endtask

    task automatic t_reset;
        rst_n = 1'b0; interval_i = 16'd10;
        repeat (3) @(negedge clk);
        #1;
        check("R1", "refresh in reset", refresh_o, 1'b0);
        check("R1", "dll in reset", dll_update_o, 1'b0);
        check("R1", "overflow in reset", overflow_o, 1'b0);
        check("R1", "hold in reset", start_hold_o, 1'b0);
    endtask

    // Idle sequencer: expiry at c9, strobe at c10, window c10..c14.
    task automatic t_idle;
        apply_reset(10);
        to_cycle(8);  settle; check("R1", "no expiry before c9", start_hold_o, 1'b0);
        to_cycle(9);  settle; check("R8", "hold at expiry", start_hold_o, 1'b1);
                              check("R3", "no strobe in expiry cycle", refresh_o, 1'b0);
        to_cycle(10); settle; check("R3", "strobe after expiry", refresh_o, 1'b1);
                              check("R9", "dll in strobe cycle", dll_update_o, 1'b1);
        to_cycle(11); settle; check("R3", "strobe single cycle", refresh_o, 1'b0);
                              check("R8", "hold released", start_hold_o, 1'b0);
        to_cycle(14); settle; check("R9", "dll last tail cycle", dll_update_o, 1'b1);
        to_cycle(15); settle; check("R9", "dll closed after tail", dll_update_o, 1'b0);
        to_cycle(19); settle; check("R2", "second expiry at c19", start_hold_o, 1'b1);
        to_cycle(20); settle; check("R2", "second strobe at c20", refresh_o, 1'b1);
    endtask

    // Burst started in the expiry cycle defers the strobe by three cycles.
    task automatic t_burst;
        apply_reset(10);
        to_cycle(9);  burst_start_i = 1; settle;
        check("R5", "no strobe in burst start", refresh_o, 1'b0);
        to_cycle(10); burst_start_i = 0; settle;
        check("R5", "no strobe c10", refresh_o, 1'b0);
        check("R8", "hold while waiting", start_hold_o, 1'b1);
        to_cycle(11); settle; check("R5", "no strobe c11", refresh_o, 1'b0);
        to_cycle(12); settle; check("R5", "strobe three cycles after expiry", refresh_o, 1'b1);
        to_cycle(18); settle; check("R6", "no drift: no hold c18", start_hold_o, 1'b0);
        to_cycle(19); settle; check("R6", "no drift: expiry c19", start_hold_o, 1'b1);
        to_cycle(20); settle; check("R6", "no drift: strobe c20", refresh_o, 1'b1);
    endtask

    // Long busy stretch: a second expiry meets the waiting request.
    task automatic t_busy_overflow;
        apply_reset(10);
        to_cycle(5); txn_busy_i = 1; settle;
        to_cycle(10); settle; check("R4", "held off while busy", refresh_o, 1'b0);
        to_cycle(19); settle; check("R7", "no overflow before second expiry", overflow_o, 1'b0);
                              check("R4", "still held off", refresh_o, 1'b0);
        to_cycle(20); settle; check("R7", "overflow set", overflow_o, 1'b1);
        to_cycle(21); txn_busy_i = 0; settle;
        check("R4", "strobe on first idle cycle", refresh_o, 1'b1);
        to_cycle(22); settle; check("R4", "single strobe after overflow", refresh_o, 1'b0);
        to_cycle(28); settle; check("R7", "overflow sticky", overflow_o, 1'b1);
        to_cycle(29); settle; check("R6", "grid kept: expiry c29", start_hold_o, 1'b1);
    endtask

    // Read during the window forces the enable low only in those cycles.
    task automatic t_read_freeze;
        apply_reset(10);
        to_cycle(5);  read_active_i = 1; settle;
        check("R10", "no dll outside window", dll_update_o, 1'b0);
        to_cycle(6);  read_active_i = 0; settle;
        to_cycle(11); settle; check("R9", "dll open c11", dll_update_o, 1'b1);
        to_cycle(12); read_active_i = 1; settle; check("R10", "dll frozen c12", dll_update_o, 1'b0);
        to_cycle(13); settle; check("R10", "dll frozen c13", dll_update_o, 1'b0);
        to_cycle(14); read_active_i = 0; settle; check("R9", "dll reopens c14", dll_update_o, 1'b1);
        to_cycle(15); settle; check("R9", "dll closed c15", dll_update_o, 1'b0);
    endtask

    // Interval changed between reloads, and an interval of one.
    task automatic t_intervals;
        apply_reset(3);
        to_cycle(2); settle; check("R2", "interval 3 expiry c2", start_hold_o, 1'b1);
        interval_i = 16'd5;
        to_cycle(3); settle; check("R3", "strobe c3", refresh_o, 1'b1);
        to_cycle(6); settle; check("R2", "new interval: no expiry c6", start_hold_o, 1'b0);
        to_cycle(7); settle; check("R2", "new interval 5: expiry c7", start_hold_o, 1'b1);
        apply_reset(1);
        for (int c = 1; c <= 4; c++) begin
            to_cycle(c); settle;
            check("R2", "interval 1 strobe every cycle", refresh_o, 1'b1);
            check("R7", "interval 1 no overflow", overflow_o, 1'b0);
        end
    endtask

    initial begin
        t_reset;
        t_idle;
        t_burst;
        t_busy_overflow;
        t_read_freeze;
        t_intervals;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule